// File: doc/BRIEF.md
# Dual-Line Interrupt Steering Unit

This block gathers eleven event pulses from a USB peripheral into two flag banks: an eight-source bank and a three-source bank. Each source has a flag, an enable bit and a line-select bit. Each enabled, pending flag is routed to one of two interrupt request outputs, called line 0 and line 1. The source's select bit picks the line.

A small register port gives software access to the banks. Software reads the flags and clears them by writing ones. It reads and writes the select and enable bits. A two-bit vector code tells the interrupt handler which line to service first. Line 0 always wins when both lines are pending.

Bank 0 holds these sources, listed from bit 0 upward:
- bit 0: endpoint-0 IN transmit done
- bit 1: endpoint-0 IN transfer request
- bit 2: endpoint-0 OUT receive done
- bit 3: setup packet received
- bit 4: endpoint-2 FIFO empty
- bit 5: endpoint-2 transfer request
- bit 6: endpoint-1 FIFO full
- bit 7: bus reset

Bank 1 holds these sources:
- bit 0: bus power connect
- bit 1: endpoint-3 transmit done
- bit 2: endpoint-3 transfer request

Top module: `irq_steer_top`

Register map, on `bus_addr`:

| Address | Register |
|---------|----------|
| 0 | Bank 0 flags |
| 1 | Bank 1 flags |
| 2 | Bank 0 selects |
| 3 | Bank 1 selects |
| 4 | Bank 0 enables |
| 5 | Bank 1 enables |
| 6, 7 | Unmapped |

## Requirements
- R1: A one-cycle high on `evt_bank0[i]` sets bit i of the bank 0 flags. A one-cycle high on `evt_bank1[j]` sets bit j of the bank 1 flags. Both changes are visible on `bus_rdata` in the cycle after the event edge.
- R2: A write to a flag address clears every flag bit whose `bus_wdata` bit is 1. Flag bits written with 0 keep their value.
- R3: When an event and a write-one-to-clear hit the same flag bit in the same cycle, the flag ends up set.
- R4: A pending, enabled source whose select bit is 0 drives `irq_line0`. One whose select bit is 1 drives `irq_line1`. Each line is the OR over all such sources of both banks.
- R5: A flag whose enable bit is 0 drives neither line.
- R6: Both lines are registered. A change in a flag, enable or select appears on the lines one clock later.
- R7: `irq_vec` is 01 when line 0 is pending, 10 when only line 1 is pending, and 00 otherwise. It is registered together with the lines.
- R8: After a synchronous active-low reset, the following hold:
  - all flags and enables are 0
  - the bank 0 selects read 0x00
  - the bank 1 selects read 0x07
  - both lines are low and the vector is 00
- R9: Bits 7 to 3 of the bank 1 flag, select and enable registers always read 0. Writes to those bits have no effect.
- R10: Addresses 6 and 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_bank0 | input | 8 | Event pulses for the bank 0 sources |
| evt_bank1 | input | 3 | Event pulses for the bank 1 sources |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` (combinational) |
| irq_line0 | output | 1 | Interrupt request line 0 |
| irq_line1 | output | 1 | Interrupt request line 1 |
| irq_vec | output | 2 | Code of the line to service first |

## Verification
Directed sequences cover the following cases:
- a flag steered to each line in turn, which shows that the select bit alone picks the line
- a flag left disabled, which separates masking from steering
- sources pending on both lines at once, which exercises line-0 priority in the vector
- an event landing on a bit that is being cleared in the same cycle, which separates set-wins from clear-wins
- writes of all ones to the reserved and unmapped addresses

Random stretches then mix sparse events with random writes to every address. A bench model predicts each register read and the line values one clock after each state change. This catches any error in the one-cycle latency or in the cross-bank OR.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
    localparam int BANK0_W = 8;
    localparam int BANK1_W = 3;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 3;

    localparam logic [ADDR_W-1:0] ADR_FLAG0 = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_FLAG1 = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_SEL0  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_SEL1  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_EN0   = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_EN1   = 3'd5;

    localparam logic [BANK0_W-1:0] BANK0_SEL_RST = '0;
    localparam logic [BANK1_W-1:0] BANK1_SEL_RST = '1;

    localparam logic [1:0] VEC_NONE = 2'b00;
    localparam logic [1:0] VEC_L0   = 2'b01;
    localparam logic [1:0] VEC_L1   = 2'b10;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
    parameter int W = 8,
    parameter logic [W-1:0] SEL_RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         wr_flag,
    input  logic         wr_sel,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] flag_o,
    output logic [W-1:0] sel_o,
    output logic [W-1:0] en_o,
    output logic         req0,
    output logic         req1
);
    typedef struct packed {
        logic [W-1:0] flag;
        logic [W-1:0] sel;
        logic [W-1:0] en;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_flag) st_d.flag = st_q.flag & ~wdata;
        // an arriving event overrides a clear in the same cycle
        st_d.flag = st_d.flag | evt;
        if (wr_sel) st_d.sel = wdata;
        if (wr_en)  st_d.en  = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.flag <= '0;
            st_q.sel  <= SEL_RST;
            st_q.en   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign sel_o  = st_q.sel;
    assign en_o   = st_q.en;
    assign req0   = |(st_q.flag & st_q.en & ~st_q.sel);
    assign req1   = |(st_q.flag & st_q.en &  st_q.sel);

    // R1 / R3: every pulsed event leaves its flag set, whatever the write did
    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((st_q.flag & $past(evt)) == $past(evt)));

    // R2: clearing all bits with no event empties the bank
    a_r2_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && (wdata == '1) && (evt == '0)) |=> (st_q.flag == '0));

    // R8: reset defaults
    a_r8_reset_state: assert property (@(posedge clk)
        !rst_n |=> (st_q.sel == SEL_RST && st_q.flag == '0 && st_q.en == '0));
endmodule

// File: rtl/irq_line_merge.sv
module irq_line_merge #(
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] req0,
    input  logic [NB-1:0] req1,
    output logic          line0,
    output logic          line1,
    output logic [1:0]    vec
);
    import irq_steer_pkg::*;

    typedef struct packed {
        logic       l0;
        logic       l1;
        logic [1:0] v;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d.l0 = |req0;
        out_d.l1 = |req1;
        if (out_d.l0)      out_d.v = VEC_L0;
        else if (out_d.l1) out_d.v = VEC_L1;
        else               out_d.v = VEC_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign line0 = out_q.l0;
    assign line1 = out_q.l1;
    assign vec   = out_q.v;

    // R6: lines trail the bank requests by one clock
    a_r6_line0_lat: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (line0 == $past(|req0)));
    a_r6_line1_lat: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (line1 == $past(|req1)));

    // R7: vector encoding and line-0 priority
    a_r7_vec_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vec));
    a_r7_vec_prio: assert property (@(posedge clk) disable iff (!rst_n)
        line0 |-> (vec == VEC_L0));
    a_r7_vec_l1: assert property (@(posedge clk) disable iff (!rst_n)
        (!line0 && line1) |-> (vec == VEC_L1));
    a_r7_vec_none: assert property (@(posedge clk) disable iff (!rst_n)
        (!line0 && !line1) |-> (vec == VEC_NONE));
endmodule

// File: rtl/irq_steer_top.sv
module irq_steer_top
    import irq_steer_pkg::*;
#(
    parameter int B0W = BANK0_W,
    parameter int B1W = BANK1_W,
    parameter int DW  = DATA_W,
    parameter int AW  = ADDR_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [B0W-1:0] evt_bank0,
    input  logic [B1W-1:0] evt_bank1,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic           irq_line0,
    output logic           irq_line1,
    output logic [1:0]     irq_vec
);
    localparam int PAD0 = DW - B0W;
    localparam int PAD1 = DW - B1W;

    logic [B0W-1:0] flag0, sel0, en0;
    logic [B1W-1:0] flag1, sel1, en1;
    logic [1:0]     req0, req1;

    logic wr_f0, wr_f1, wr_s0, wr_s1, wr_e0, wr_e1;

    always_comb begin
        wr_f0 = bus_wr && (bus_addr == ADR_FLAG0);
        wr_f1 = bus_wr && (bus_addr == ADR_FLAG1);
        wr_s0 = bus_wr && (bus_addr == ADR_SEL0);
        wr_s1 = bus_wr && (bus_addr == ADR_SEL1);
        wr_e0 = bus_wr && (bus_addr == ADR_EN0);
        wr_e1 = bus_wr && (bus_addr == ADR_EN1);
    end

    irq_src_bank #(.W(B0W), .SEL_RST(B0W'(BANK0_SEL_RST))) u_bank0 (
        .clk(clk), .rst_n(rst_n), .evt(evt_bank0),
        .wr_flag(wr_f0), .wr_sel(wr_s0), .wr_en(wr_e0),
        .wdata(bus_wdata[B0W-1:0]),
        .flag_o(flag0), .sel_o(sel0), .en_o(en0),
        .req0(req0[0]), .req1(req1[0])
    );

    irq_src_bank #(.W(B1W), .SEL_RST(B1W'(BANK1_SEL_RST))) u_bank1 (
        .clk(clk), .rst_n(rst_n), .evt(evt_bank1),
        .wr_flag(wr_f1), .wr_sel(wr_s1), .wr_en(wr_e1),
        .wdata(bus_wdata[B1W-1:0]),
        .flag_o(flag1), .sel_o(sel1), .en_o(en1),
        .req0(req0[1]), .req1(req1[1])
    );

    irq_line_merge #(.NB(2)) u_merge (
        .clk(clk), .rst_n(rst_n), .req0(req0), .req1(req1),
        .line0(irq_line0), .line1(irq_line1), .vec(irq_vec)
    );

    always_comb begin
        case (bus_addr)
            ADR_FLAG0: bus_rdata = {{PAD0{1'b0}}, flag0};
            ADR_FLAG1: bus_rdata = {{PAD1{1'b0}}, flag1};
            ADR_SEL0:  bus_rdata = {{PAD0{1'b0}}, sel0};
            ADR_SEL1:  bus_rdata = {{PAD1{1'b0}}, sel1};
            ADR_EN0:   bus_rdata = {{PAD0{1'b0}}, en0};
            ADR_EN1:   bus_rdata = {{PAD1{1'b0}}, en1};
            default:   bus_rdata = '0;
        endcase
    end

    // R10: a write to an unmapped address leaves the readable state unchanged
    a_r10_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr > ADR_EN1 && evt_bank0 == '0 && evt_bank1 == '0)
        |=> ($stable(sel0) && $stable(sel1) && $stable(en0) && $stable(en1)
             && $stable(flag0) && $stable(flag1)));
endmodule

// File: tb/irq_steer_top_test.sv
module irq_steer_top_test;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [7:0] evt_bank0 = 0;
    logic [2:0] evt_bank1 = 0;
    logic       bus_wr = 0;
    logic [2:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       irq_line0, irq_line1;
    logic [1:0] irq_vec;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_f0, m_s0, m_e0;
    logic [2:0] m_f1, m_s1, m_e1;

    always #5 clk = ~clk;

    irq_steer_top uut (
        .clk(clk), .rst_n(rst_n), .evt_bank0(evt_bank0), .evt_bank1(evt_bank1),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_line0(irq_line0), .irq_line1(irq_line1),
        .irq_vec(irq_vec)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic exp_l0();
        return |(m_f0 & m_e0 & ~m_s0) | |(m_f1 & m_e1 & ~m_s1);
    endfunction

    function automatic logic exp_l1();
        return |(m_f0 & m_e0 & m_s0) | |(m_f1 & m_e1 & m_s1);
    endfunction

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return m_f0;
            3'd1: return {5'b0, m_f1};
            3'd2: return m_s0;
            3'd3: return {5'b0, m_s1};
            3'd4: return m_e0;
            3'd5: return {5'b0, m_e1};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [1:0] exp_vec(input logic l0, input logic l1);
        return l0 ? 2'b01 : (l1 ? 2'b10 : 2'b00);
    endfunction

    task automatic step(input string tag, input logic [7:0] e0, input logic [2:0] e1,
                        input logic wr, input logic [2:0] a, input logic [7:0] wd);
        logic pl0, pl1;
        @(negedge clk);
        evt_bank0 = e0; evt_bank1 = e1;
        bus_wr = wr; bus_addr = a; bus_wdata = wd;
        pl0 = exp_l0();
        pl1 = exp_l1();
        @(posedge clk);
        #1;
        if (wr) begin
            case (a)
                3'd0: m_f0 = m_f0 & ~wd;
                3'd1: m_f1 = m_f1 & ~wd[2:0];
                3'd2: m_s0 = wd;
                3'd3: m_s1 = wd[2:0];
                3'd4: m_e0 = wd;
                3'd5: m_e1 = wd[2:0];
                default: ;
            endcase
        end
        m_f0 = m_f0 | e0;
        m_f1 = m_f1 | e1;
        chk({tag, " line0"}, {7'b0, irq_line0}, {7'b0, pl0});
        chk({tag, " line1"}, {7'b0, irq_line1}, {7'b0, pl1});
        chk({tag, " vec"}, {6'b0, irq_vec}, {6'b0, exp_vec(pl0, pl1)});
        chk({tag, " read"}, bus_rdata, exp_read(a));
        evt_bank0 = 0; evt_bank1 = 0; bus_wr = 0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_f0 = 0; m_s0 = 0; m_e0 = 0;
        m_f1 = 0; m_s1 = 3'b111; m_e1 = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R8: reset state of lines and registers
        chk("R8 line0", {7'b0, irq_line0}, 8'h00);
        chk("R8 vec", {6'b0, irq_vec}, 8'h00);
        for (int a = 0; a < 8; a++) step("R8", 0, 0, 0, 3'(a), 0);
        step("R8 sel1", 0, 0, 0, 3'd3, 0);
        chk("R8 sel1 value", bus_rdata, 8'h07);

        // R5: a flag with its enable off drives no line
        step("R1", 8'h08, 0, 0, 3'd0, 0);
        step("R5", 0, 0, 0, 3'd0, 0);
        chk("R5 masked", {7'b0, irq_line0}, 8'h00);
        // R4: enable it on line 0, then steer to line 1
        step("R4", 0, 0, 1, 3'd4, 8'h08);
        step("R6", 0, 0, 0, 3'd0, 0);
        chk("R4 line0 up", {7'b0, irq_line0}, 8'h01);
        step("R4", 0, 0, 1, 3'd2, 8'h08);
        step("R4", 0, 0, 0, 3'd2, 0);
        chk("R4 line1 up", {7'b0, irq_line1}, 8'h01);
        chk("R7 only line1", {6'b0, irq_vec}, 8'h02);
        // R7: bank 1 source on line 0 too -> priority to line 0
        step("R7", 0, 3'b001, 1, 3'd5, 8'h01);
        step("R7", 0, 0, 1, 3'd3, 8'h00);
        step("R7", 0, 0, 0, 3'd1, 0);
        chk("R7 both", {6'b0, irq_vec}, 8'h01);
        // R3: event and clear on the same bit
        step("R3", 8'h08, 0, 1, 3'd0, 8'hFF);
        chk("R3 set wins", bus_rdata, 8'h08);
        // R2: clear with zero bits keeps, one bits clear
        step("R2", 0, 0, 1, 3'd0, 8'h00);
        chk("R2 keep", bus_rdata, 8'h08);
        step("R2", 0, 0, 1, 3'd0, 8'h08);
        chk("R2 cleared", bus_rdata, 8'h00);
        // R9: reserved bits of bank 1
        step("R9", 0, 0, 1, 3'd3, 8'hFF);
        chk("R9 sel1", bus_rdata, 8'h07);
        step("R9", 0, 0, 1, 3'd5, 8'hF8);
        chk("R9 en1", bus_rdata, 8'h00);
        // R10: unmapped addresses
        step("R10", 0, 0, 1, 3'd6, 8'hFF);
        step("R10", 0, 0, 1, 3'd7, 8'hFF);
        chk("R10 read", bus_rdata, 8'h00);
        for (int a = 0; a < 6; a++) step("R10 state", 0, 0, 0, 3'(a), 0);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] e0;
            logic [2:0] e1;
            e0 = (($urandom % 4) == 0) ? 8'($urandom) & 8'($urandom) : 8'h00;
            e1 = (($urandom % 4) == 0) ? 3'($urandom) : 3'h0;
            step("R6 random", e0, e1, (($urandom % 3) == 0), 3'($urandom), 8'($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule